// File: doc/BRIEF.md
# Receive Character Synchronization Tracker

This block sits behind the character decoder of one serial receive channel. On every character strobe it gets that character's decode flags: whether the character failed to decode and whether it is a framing character. It also gets two link-fault levels, one for elasticity-buffer slip and one for receive PLL unlock. From these it tracks whether the channel is framed and can be trusted.

The tracker has three states: hunting, resynchronizing and locked. While locked it keeps two counters. One counts back-to-back decode failures. The other is a running score that goes up on each bad character and down on each good one, and it never drops below zero. Either counter reaching its limit throws the channel back into hunting. A link fault does the same at once.

Each character comes out one clock later together with a 3-bit status code. The code names the tracker's state after that character. While locked, the code also says what kind of character it was.

Top module: `rx_sync_tracker`

## Requirements
- R1: After reset the tracker is hunting, `outStrobe` is 0 and `outStatus` is 3'b111.
- R2: When `bufSlip` or `pllUnlock` is high on a clock edge, the tracker is hunting after that edge, whether or not a character is present. The fault wins over a framing character in the same cycle, so that character gets status 3'b111.
- R3: While locked, the fourth decode failure in a row returns the tracker to hunting, and that fourth character gets status 3'b111. Any good character resets the run.
- R4: While locked, the score rises by one on each failed character and falls by one on each good character, and it holds at zero. The character that brings the score to four returns the tracker to hunting, with status 3'b111.
- R5: While hunting, a framing character (`chrFrame`=1, `chrBad`=0) moves the tracker to resynchronizing with status 3'b101. Any other character leaves it hunting with status 3'b111.
- R6: While resynchronizing, a good non-framing character moves the tracker to locked with status 3'b000. A framing character keeps it resynchronizing (3'b101). A failed character sends it back to hunting (3'b111).
- R7: While locked and staying locked, status is 3'b000 for a data character, 3'b001 for a framing character and 3'b010 for a failed character (`chrBad` has priority over `chrFrame`).
- R8: Both counters clear whenever the tracker enters hunting. Counting restarts from zero after it locks again.
- R9: `outStrobe`, `outData` and `outStatus` are registered. They show the character strobed on the previous clock edge, and `outStrobe` is 0 after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| chrStrobe | input | 1 | A character is present this cycle |
| chrData | input | 8 | Decoded character value |
| chrBad | input | 1 | Character failed to decode |
| chrFrame | input | 1 | Character is a framing character |
| bufSlip | input | 1 | Elasticity buffer under/overrun |
| pllUnlock | input | 1 | Receive PLL out of lock |
| outStrobe | output | 1 | Registered character strobe |
| outData | output | 8 | Registered character value |
| outStatus | output | 3 | Status code for the registered character |

## Verification
The counters are driven with three kinds of locked-state patterns. Four failures in a row trip the run counter. Failures broken up by a single good character trip only the score. Good characters sent while the score is already zero show whether the score saturates or wraps. A fourth pattern builds a partial failure run, forces a loss, relocks and then sends three failures. This shows whether stale counts survive into the new lock. Framing, data and failed characters are also sent in each state, so every transition and status code is seen at the output. Faults arrive both with and without a character in the same cycle.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_LOCK  = 2'd2
  } sync_state_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic clear;
    logic countBad;
    logic countGood;
  } cnt_cmd_t;

  localparam logic [2:0] CODE_HUNT      = 3'b111;
  localparam logic [2:0] CODE_ALIGN     = 3'b101;
  localparam logic [2:0] CODE_LOCK_DATA = 3'b000;
  localparam logic [2:0] CODE_LOCK_FRM  = 3'b001;
  localparam logic [2:0] CODE_LOCK_BAD  = 3'b010;

endpackage

// File: rtl/rx_sync_ctrl.sv
module rx_sync_ctrl
  import rx_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chrStrobe,
  input  logic        chrBad,
  input  logic        chrFrame,
  input  logic        bufSlip,
  input  logic        pllUnlock,
  input  logic        nearLimit,
  output cnt_cmd_t    cntCmd,
  output logic [2:0]  statusCode
);

  sync_state_t state, nextState;
  logic        linkFault;

  assign linkFault = bufSlip | pllUnlock;

  always_comb begin
    nextState = state;
    cntCmd    = '0;
    if (linkFault) begin
      nextState    = ST_HUNT;
      cntCmd.clear = 1'b1;
    end else if (chrStrobe) begin
      unique case (state)
        ST_HUNT: begin
          if (!chrBad && chrFrame) nextState = ST_ALIGN;
        end
        ST_ALIGN: begin
          if (chrBad) begin
            nextState    = ST_HUNT;
            cntCmd.clear = 1'b1;
          end else if (!chrFrame) begin
            nextState = ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (chrBad) begin
            cntCmd.countBad = 1'b1;
            if (nearLimit) begin
              nextState    = ST_HUNT;
              cntCmd.clear = 1'b1;
            end
          end else begin
            cntCmd.countGood = 1'b1;
          end
        end
        default: nextState = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    unique case (nextState)
      ST_ALIGN: statusCode = CODE_ALIGN;
      ST_LOCK: begin
        if (chrBad)        statusCode = CODE_LOCK_BAD;
        else if (chrFrame) statusCode = CODE_LOCK_FRM;
        else               statusCode = CODE_LOCK_DATA;
      end
      default: statusCode = CODE_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  // R1: first cycle out of reset finds the hunting state
  assert_reset_hunt_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> state == ST_HUNT);

  // R2: a link fault always lands in hunting
  assert_fault_hunt_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bufSlip || pllUnlock) |=> state == ST_HUNT);

  // R6: lock is only ever entered from resynchronizing
  assert_lock_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && $past(state) != ST_LOCK) |-> $past(state) == ST_ALIGN);

  // R3/R4: a failed character at the counter limit ends the lock
  assert_limit_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && chrStrobe && chrBad && nearLimit) |=> state == ST_HUNT);

endmodule

// File: rtl/rx_sync_dp.sv
module rx_sync_dp
  import rx_sync_pkg::*;
#(
  parameter int DataW      = 8,
  parameter int RunLimit   = 4,
  parameter int ScoreLimit = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cntCmd,
  input  logic             chrStrobe,
  input  logic [DataW-1:0] chrData,
  input  logic [2:0]       statusCode,
  output logic             nearLimit,
  output logic             outStrobe,
  output logic [DataW-1:0] outData,
  output logic [2:0]       outStatus
);

  localparam int RunW   = $clog2(RunLimit + 1);
  localparam int ScoreW = $clog2(ScoreLimit + 1);
  localparam logic [RunW-1:0]   RunLast   = RunW'(RunLimit - 1);
  localparam logic [ScoreW-1:0] ScoreLast = ScoreW'(ScoreLimit - 1);

  logic [RunW-1:0]   runCnt;
  logic [ScoreW-1:0] scoreCnt;

  assign nearLimit = (runCnt == RunLast) || (scoreCnt >= ScoreLast);

  always_ff @(posedge clk) begin
    if (!rstN || cntCmd.clear) begin
      runCnt   <= '0;
      scoreCnt <= '0;
    end else if (cntCmd.countBad) begin
      if (runCnt != RunW'(RunLimit))       runCnt   <= runCnt + 1'b1;
      if (scoreCnt != ScoreW'(ScoreLimit)) scoreCnt <= scoreCnt + 1'b1;
    end else if (cntCmd.countGood) begin
      runCnt <= '0;
      if (scoreCnt != '0) scoreCnt <= scoreCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outStrobe <= 1'b0;
      outData   <= '0;
      outStatus <= CODE_HUNT;
    end else begin
      outStrobe <= chrStrobe;
      if (chrStrobe || cntCmd.clear) outStatus <= statusCode;
      if (chrStrobe) outData <= chrData;
    end
  end

  // R4: the score never goes below zero on a good character
  assert_score_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cntCmd.countGood && !cntCmd.clear && scoreCnt == '0) |=> scoreCnt == '0);

  // R8: a clear request leaves both counters empty
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    cntCmd.clear |=> (runCnt == '0 && scoreCnt == '0));

  // R9: output strobe follows the input strobe by one cycle
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    outStrobe == $past(chrStrobe));

endmodule

// File: rtl/rx_sync_tracker.sv
module rx_sync_tracker
  import rx_sync_pkg::*;
#(
  parameter int DataW      = 8,
  parameter int RunLimit   = 4,
  parameter int ScoreLimit = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chrStrobe,
  input  logic [DataW-1:0] chrData,
  input  logic             chrBad,
  input  logic             chrFrame,
  input  logic             bufSlip,
  input  logic             pllUnlock,
  output logic             outStrobe,
  output logic [DataW-1:0] outData,
  output logic [2:0]       outStatus
);

  cnt_cmd_t   cntCmd;
  logic       nearLimit;
  logic [2:0] statusCode;

  rx_sync_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chrStrobe  (chrStrobe),
    .chrBad     (chrBad),
    .chrFrame   (chrFrame),
    .bufSlip    (bufSlip),
    .pllUnlock  (pllUnlock),
    .nearLimit  (nearLimit),
    .cntCmd     (cntCmd),
    .statusCode (statusCode)
  );

  rx_sync_dp #(
    .DataW      (DataW),
    .RunLimit   (RunLimit),
    .ScoreLimit (ScoreLimit)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cntCmd     (cntCmd),
    .chrStrobe  (chrStrobe),
    .chrData    (chrData),
    .statusCode (statusCode),
    .nearLimit  (nearLimit),
    .outStrobe  (outStrobe),
    .outData    (outData),
    .outStatus  (outStatus)
  );

endmodule

// File: tb/test_rx_sync_tracker.sv
module test_rx_sync_tracker;

  logic       clk = 1'b0;
  logic       rstN;
  logic       chrStrobe, chrBad, chrFrame, bufSlip, pllUnlock;
  logic [7:0] chrData;
  logic       outStrobe;
  logic [7:0] outData;
  logic [2:0] outStatus;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  localparam logic [2:0] HUNT = 3'b111, ALIGN = 3'b101, LDATA = 3'b000,
                         LFRM = 3'b001, LBAD = 3'b010;

  always #2 clk = ~clk;

  rx_sync_tracker i_rx_sync_tracker (
    .clk(clk), .rstN(rstN), .chrStrobe(chrStrobe), .chrData(chrData),
    .chrBad(chrBad), .chrFrame(chrFrame), .bufSlip(bufSlip),
    .pllUnlock(pllUnlock), .outStrobe(outStrobe), .outData(outData),
    .outStatus(outStatus)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample just after the rising edge
  task automatic step(input bit stb, input logic [7:0] d, input bit bad,
                      input bit frm, input bit slip, input bit unlock);
    @(negedge clk);
    chrStrobe = stb; chrData = d; chrBad = bad; chrFrame = frm;
    bufSlip = slip; pllUnlock = unlock;
    @(posedge clk);
    #1;
  endtask

  task automatic sendChk(input string req, input logic [7:0] d, input bit bad,
                         input bit frm, input logic [2:0] expStatus);
    step(1, d, bad, frm, 0, 0);
    check(req, int'(outStatus), int'(expStatus));
  endtask

  task automatic forceHunt();
    step(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic relock(input string req);
    forceHunt();
    sendChk(req, 8'hBC, 0, 1, ALIGN);
    sendChk(req, 8'h11, 0, 0, LDATA);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    step(0, 8'h00, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0);
    rstN = 1'b1;
    check("R1 status", int'(outStatus), int'(HUNT));
    check("R1 strobe", int'(outStrobe), 0);
  endtask

  task automatic t_hunt();
    forceHunt();
    sendChk("R5 data in hunt", 8'h42, 0, 0, HUNT);
    sendChk("R5 bad in hunt", 8'h43, 1, 1, HUNT);
    sendChk("R5 frame to align", 8'hBC, 0, 1, ALIGN);
  endtask

  task automatic t_latency();
    step(1, 8'h5A, 0, 0, 0, 0);
    check("R9 strobe", int'(outStrobe), 1);
    check("R9 data", int'(outData), 8'h5A);
    step(0, 8'hFF, 0, 0, 0, 0);
    check("R9 idle strobe", int'(outStrobe), 0);
    check("R9 data held", int'(outData), 8'h5A);
  endtask

  task automatic t_align();
    forceHunt();
    sendChk("R6 frame", 8'hBC, 0, 1, ALIGN);
    sendChk("R6 frame stays", 8'hBC, 0, 1, ALIGN);
    sendChk("R6 bad drops", 8'h00, 1, 0, HUNT);
    sendChk("R6 frame again", 8'hBC, 0, 1, ALIGN);
    sendChk("R6 data locks", 8'h21, 0, 0, LDATA);
  endtask

  task automatic t_lockCodes();
    relock("R7 relock");
    sendChk("R7 frame code", 8'hBC, 0, 1, LFRM);
    sendChk("R7 bad code", 8'h00, 1, 0, LBAD);
    sendChk("R7 bad over frame", 8'hBC, 1, 1, LBAD);
    sendChk("R7 data code", 8'h33, 0, 0, LDATA);
  endtask

  task automatic t_run();
    relock("R3 relock");
    sendChk("R3 bad1", 8'h00, 1, 0, LBAD);
    sendChk("R3 bad2", 8'h00, 1, 0, LBAD);
    sendChk("R3 bad3", 8'h00, 1, 0, LBAD);
    sendChk("R3 bad4 loses", 8'h00, 1, 0, HUNT);
    sendChk("R3 stays hunt", 8'h44, 0, 0, HUNT);
  endtask

  task automatic t_score();
    relock("R4 relock");
    sendChk("R4 s1", 8'h00, 1, 0, LBAD);
    sendChk("R4 s2", 8'h00, 1, 0, LBAD);
    sendChk("R4 s3", 8'h00, 1, 0, LBAD);
    sendChk("R4 good", 8'h55, 0, 0, LDATA);
    sendChk("R4 s3 again", 8'h00, 1, 0, LBAD);
    sendChk("R4 score four", 8'h00, 1, 0, HUNT);
  endtask

  task automatic t_floor();
    relock("R4 floor relock");
    sendChk("R4 good at zero", 8'h01, 0, 0, LDATA);
    sendChk("R4 good at zero2", 8'h02, 0, 0, LDATA);
    sendChk("R4 f1", 8'h00, 1, 0, LBAD);
    sendChk("R4 f2", 8'h00, 1, 0, LBAD);
    sendChk("R4 f3", 8'h00, 1, 0, LBAD);
    sendChk("R4 f good", 8'h03, 0, 0, LDATA);
    sendChk("R4 f bad", 8'h00, 1, 0, LBAD);
    sendChk("R4 f limit", 8'h00, 1, 0, HUNT);
  endtask

  task automatic t_fault();
    relock("R2 relock");
    step(0, 8'h00, 0, 0, 0, 1);
    sendChk("R2 unlock no char", 8'h66, 0, 0, HUNT);
    relock("R2 relock2");
    step(1, 8'hBC, 0, 1, 1, 0);
    check("R2 slip beats frame", int'(outStatus), int'(HUNT));
    sendChk("R2 after slip", 8'h67, 0, 0, HUNT);
  endtask

  task automatic t_clear();
    relock("R8 relock");
    sendChk("R8 pre1", 8'h00, 1, 0, LBAD);
    sendChk("R8 pre2", 8'h00, 1, 0, LBAD);
    sendChk("R8 pre3", 8'h00, 1, 0, LBAD);
    relock("R8 relock2");
    sendChk("R8 post1", 8'h00, 1, 0, LBAD);
    sendChk("R8 post2", 8'h00, 1, 0, LBAD);
    sendChk("R8 post3", 8'h00, 1, 0, LBAD);
    sendChk("R8 post4", 8'h00, 1, 0, HUNT);
  endtask

  initial begin
    chrStrobe = 0; chrData = 0; chrBad = 0; chrFrame = 0;
    bufSlip = 0; pllUnlock = 0; rstN = 0;
    t_reset();
    t_hunt();
    t_latency();
    t_align();
    t_lockCodes();
    t_run();
    t_score();
    t_floor();
    t_fault();
    t_clear();
    step(0, 8'h00, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule